// File: doc/BRIEF.md
# Interrupt Flag and Wake-up Controller

This block holds the interrupt state of a small 8-bit microcontroller. Five event sources feed it: two external pins, a comparator output, a group of port inputs and a timer overflow pulse. Each source has a flag that hardware sets when its event occurs, and software can only clear it. Software reaches the flags, the per-source mask bits and two wake-up enable bits through three byte-wide registers on a simple read/write bus.

An interrupt request goes out when a flag and its mask bit are both set and the global enable is on. An enable-interrupts strobe turns the global enable on, and a disable-interrupts strobe turns it off. While the core reports that it is asleep, a port change or a comparator change whose wake enable is set produces a one-cycle wake pulse. Timer and pin events can still raise flags, but they cannot end sleep.

Pin inputs pass through a synchronizer and are detected on their falling edge. The comparator output and the port inputs are synchronized and compared with their previous sampled value, so any change in level counts as an event.

Top module: `irq_wake_ctrl`

## Requirements
- R1: After reset, all three registers read 0x00, and `irq` and `wake` are 0.
- R2: The wake-control register (address 0) has the external-1 flag at bit 7, the port wake enable at bit 4, the comparator wake enable at bit 2 and the comparator flag at bit 0. The status register (address 1) has the external-0 flag at bit 2, the port-change flag at bit 1 and the timer flag at bit 0. The mask register (address 2) has the external-1 mask at bit 4, comparator at bit 3, external-0 at bit 2, port at bit 1 and timer at bit 0. All other bits read 0, even after a write of 1s.
- R3: A falling edge on `ext0_pin` or `ext1_pin` sets its flag on the third rising clock edge after the pin changes. A rising edge sets nothing.
- R4: A comparator output change in either direction sets the comparator flag with the same latency as R3.
- R5: A change on any bit of `port_in` sets the port-change flag with the same latency as R3. A high `tmr_ovf` in a cycle sets the timer flag at the next clock edge.
- R6: A register write of 0 to a flag bit clears that flag. A write of 1 leaves it unchanged and never sets it.
- R7: When a hardware set and a software clear of the same flag fall in the same cycle, the flag ends up set.
- R8: `irq` is high exactly when the global enable is on and at least one flag has its mask bit set.
- R9: `ei_strobe` turns the global enable on at the next edge and `di_strobe` turns it off. When both strobes are high in the same cycle, disable wins.
- R10: `wake` is a one-cycle pulse, issued in the same cycle the flag becomes visible, only when `sleep` is high and a port change (with port wake enable set) or a comparator change (with comparator wake enable set) occurs. Without the enable, or while awake, there is no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ext0_pin | input | 1 | External interrupt pin 0, asynchronous |
| ext1_pin | input | 1 | External interrupt pin 1, asynchronous |
| cmp_out | input | 1 | Comparator digital output, asynchronous |
| port_in | input | PORT_W | Port inputs watched for change, asynchronous |
| tmr_ovf | input | 1 | Timer overflow pulse, synchronous |
| reg_addr | input | 2 | Register select |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected register |
| ei_strobe | input | 1 | Enable-interrupts strobe |
| di_strobe | input | 1 | Disable-interrupts strobe |
| sleep | input | 1 | Core is asleep |
| irq | output | 1 | Interrupt request |
| wake | output | 1 | One-cycle wake-up pulse |

## Verification
The assertions check on every cycle that the spare register bits read as zero, that the timer flag rises only after an overflow pulse and falls only after a clearing write, that an overflow beats a clear in the same cycle, that `irq` never appears without a masked-in flag or right after a disable strobe, and that `wake` never appears unless the core was asleep. Some behaviours can only be shown by the bench's scenarios: the three-edge synchronizer latency, a rising pin edge being ignored, the comparator firing in both directions, and wake being withheld when its enable is clear. The scenarios drive each case and compare the registers and outputs in the exact cycle they are expected to change.

// File: rtl/irq_wake_pkg.sv
// Package irq_wake_pkg
// Shared constants for the interrupt flag and wake-up controller: source
// indices into the flag and mask vectors, register addresses, and the bit
// positions of fields inside the byte-wide registers.
package irq_wake_pkg;

    localparam int DATA_W  = 8;
    localparam int NUM_SRC = 5;
    localparam int REG_AW  = 2;

    // Source index in flag/mask vectors; mask register uses the same bit order
    localparam int SRC_TMR  = 0;
    localparam int SRC_PORT = 1;
    localparam int SRC_EXT0 = 2;
    localparam int SRC_CMP  = 3;
    localparam int SRC_EXT1 = 4;

    typedef logic [REG_AW-1:0] reg_addr_t;

    localparam reg_addr_t ADDR_WCTL = 2'd0;
    localparam reg_addr_t ADDR_STAT = 2'd1;
    localparam reg_addr_t ADDR_MASK = 2'd2;

    // Wake-control register field positions
    localparam int WCTL_EXT1_BIT = 7;
    localparam int WCTL_PWE_BIT  = 4;
    localparam int WCTL_CWE_BIT  = 2;
    localparam int WCTL_CMP_BIT  = 0;

    // Status register field positions
    localparam int STAT_EXT0_BIT = 2;
    localparam int STAT_PORT_BIT = 1;
    localparam int STAT_TMR_BIT  = 0;

    typedef enum logic {
        DET_FALL   = 1'b0,
        DET_CHANGE = 1'b1
    } det_mode_e;

endpackage

// File: rtl/irq_event_sync.sv
// Module irq_event_sync
// Brings WIDTH asynchronous inputs into the clock domain through STAGES
// flip-flops, keeps one more stage as the previous sample, and flags an
// event per bit: a high-to-low transition (DET_FALL) or any level change
// (DET_CHANGE). Assumes inputs are held at least two clock periods.
module irq_event_sync
    import irq_wake_pkg::*;
#(
    parameter int        WIDTH  = 1,
    parameter int        STAGES = 2,
    parameter det_mode_e MODE   = DET_FALL
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] raw_in,
    output logic [WIDTH-1:0] evt
);

    localparam int DEPTH = STAGES + 1;

    logic [WIDTH-1:0] pipe [DEPTH];
    logic [WIDTH-1:0] cur_s;
    logic [WIDTH-1:0] prev_s;

    // Shift the raw input through the synchronizer and history stage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                pipe[i] <= '0;
            end
        end else begin
            pipe[0] <= raw_in;
            for (int i = 1; i < DEPTH; i++) begin
                pipe[i] <= pipe[i-1];
            end
        end
    end

    assign cur_s  = pipe[STAGES-1];
    assign prev_s = pipe[STAGES];

    // Per-bit detector chosen by MODE
    for (genvar b = 0; b < WIDTH; b++) begin : g_det
        if (MODE == DET_FALL) begin : g_fall
            assign evt[b] = prev_s[b] & ~cur_s[b];
        end else begin : g_chg
            assign evt[b] = prev_s[b] ^ cur_s[b];
        end
    end

endmodule

// File: rtl/irq_flag_bank.sv
// Module irq_flag_bank
// Holds the event flags, per-source masks, the two wake enables and the
// global interrupt enable, and decodes the register bus. Flags are set by
// hardware and cleared only by writing 0; a set in the same cycle as a
// clear wins. Reads are combinational on reg_addr.
module irq_flag_bank
    import irq_wake_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] set_vec,
    input  reg_addr_t          reg_addr,
    input  logic               reg_wr,
    input  logic [DATA_W-1:0]  reg_wdata,
    input  logic               ei_strobe,
    input  logic               di_strobe,
    output logic [DATA_W-1:0]  reg_rdata,
    output logic [NUM_SRC-1:0] flags,
    output logic [NUM_SRC-1:0] mask,
    output logic               port_we,
    output logic               cmp_we,
    output logic               gie
);

    logic [NUM_SRC-1:0] clr_vec;
    logic               wr_wctl;
    logic               wr_stat;
    logic               wr_mask;
    logic               unused_wdata;

    assign wr_wctl = reg_wr && (reg_addr == ADDR_WCTL);
    assign wr_stat = reg_wr && (reg_addr == ADDR_STAT);
    assign wr_mask = reg_wr && (reg_addr == ADDR_MASK);
    assign unused_wdata = ^reg_wdata[DATA_W-2:NUM_SRC];

    // Build the clear vector from a zero written into a flag field
    always_comb begin
        clr_vec = '0;
        if (wr_wctl) begin
            clr_vec[SRC_EXT1] = ~reg_wdata[WCTL_EXT1_BIT];
            clr_vec[SRC_CMP]  = ~reg_wdata[WCTL_CMP_BIT];
        end
        if (wr_stat) begin
            clr_vec[SRC_EXT0] = ~reg_wdata[STAT_EXT0_BIT];
            clr_vec[SRC_PORT] = ~reg_wdata[STAT_PORT_BIT];
            clr_vec[SRC_TMR]  = ~reg_wdata[STAT_TMR_BIT];
        end
    end

    // Update flags: clear first, then OR in hardware sets so sets win
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags <= '0;
        end else begin
            flags <= (flags & ~clr_vec) | set_vec;
        end
    end

    // Load mask and wake enables from ordinary writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask    <= '0;
            port_we <= 1'b0;
            cmp_we  <= 1'b0;
        end else begin
            if (wr_mask) begin
                mask <= reg_wdata[NUM_SRC-1:0];
            end
            if (wr_wctl) begin
                port_we <= reg_wdata[WCTL_PWE_BIT];
                cmp_we  <= reg_wdata[WCTL_CWE_BIT];
            end
        end
    end

    // Global enable: disable strobe has priority over enable strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gie <= 1'b0;
        end else if (di_strobe) begin
            gie <= 1'b0;
        end else if (ei_strobe) begin
            gie <= 1'b1;
        end
    end

    // Assemble the selected register for reading; spare bits stay 0
    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            ADDR_WCTL: begin
                reg_rdata[WCTL_EXT1_BIT] = flags[SRC_EXT1];
                reg_rdata[WCTL_PWE_BIT]  = port_we;
                reg_rdata[WCTL_CWE_BIT]  = cmp_we;
                reg_rdata[WCTL_CMP_BIT]  = flags[SRC_CMP];
            end
            ADDR_STAT: begin
                reg_rdata[STAT_EXT0_BIT] = flags[SRC_EXT0];
                reg_rdata[STAT_PORT_BIT] = flags[SRC_PORT];
                reg_rdata[STAT_TMR_BIT]  = flags[SRC_TMR];
            end
            ADDR_MASK: begin
                reg_rdata[NUM_SRC-1:0] = mask;
            end
            default: begin
                reg_rdata = '0;
            end
        endcase
    end

endmodule

// File: rtl/irq_out_stage.sv
// Module irq_out_stage
// Forms the interrupt request from flags, masks and the global enable, and
// registers a one-cycle wake pulse when a wake-capable source sets its flag
// while the core sleeps. Assumes set strobes are single-cycle events.
module irq_out_stage
    import irq_wake_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] flags,
    input  logic [NUM_SRC-1:0] mask,
    input  logic               gie,
    input  logic               port_set,
    input  logic               cmp_set,
    input  logic               port_we,
    input  logic               cmp_we,
    input  logic               sleep,
    output logic               irq,
    output logic               wake
);

    logic wake_hit;

    assign irq      = gie & (|(flags & mask));
    assign wake_hit = sleep & ((port_set & port_we) | (cmp_set & cmp_we));

    // Register the wake pulse so it lines up with the flag update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wake <= 1'b0;
        end else begin
            wake <= wake_hit;
        end
    end

endmodule

// File: rtl/irq_wake_ctrl.sv
// Module irq_wake_ctrl
// Top of the interrupt flag and wake-up controller. Synchronizes pin,
// comparator and port inputs, collects the five set strobes, and hands them
// to the flag bank and output stage. Assumes tmr_ovf is already synchronous.
module irq_wake_ctrl
    import irq_wake_pkg::*;
#(
    parameter int PORT_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext0_pin,
    input  logic              ext1_pin,
    input  logic              cmp_out,
    input  logic [PORT_W-1:0] port_in,
    input  logic              tmr_ovf,
    input  logic [1:0]        reg_addr,
    input  logic              reg_wr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic              ei_strobe,
    input  logic              di_strobe,
    input  logic              sleep,
    output logic              irq,
    output logic              wake
);

    logic [1:0]         ext_evt;
    logic               cmp_evt;
    logic [PORT_W-1:0]  port_evt;
    logic [NUM_SRC-1:0] set_vec;
    logic [NUM_SRC-1:0] flags;
    logic [NUM_SRC-1:0] mask;
    logic               port_we;
    logic               cmp_we;
    logic               gie;

    irq_event_sync #(
        .WIDTH (2),
        .STAGES(SYNC_STAGES),
        .MODE  (DET_FALL)
    ) u_ext_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .raw_in({ext1_pin, ext0_pin}),
        .evt   (ext_evt)
    );

    irq_event_sync #(
        .WIDTH (1),
        .STAGES(SYNC_STAGES),
        .MODE  (DET_CHANGE)
    ) u_cmp_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .raw_in(cmp_out),
        .evt   (cmp_evt)
    );

    irq_event_sync #(
        .WIDTH (PORT_W),
        .STAGES(SYNC_STAGES),
        .MODE  (DET_CHANGE)
    ) u_port_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .raw_in(port_in),
        .evt   (port_evt)
    );

    // Gather per-source set strobes in source-index order
    always_comb begin
        set_vec           = '0;
        set_vec[SRC_TMR]  = tmr_ovf;
        set_vec[SRC_PORT] = |port_evt;
        set_vec[SRC_EXT0] = ext_evt[0];
        set_vec[SRC_CMP]  = cmp_evt;
        set_vec[SRC_EXT1] = ext_evt[1];
    end

    irq_flag_bank u_flag_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_vec  (set_vec),
        .reg_addr (reg_addr),
        .reg_wr   (reg_wr),
        .reg_wdata(reg_wdata),
        .ei_strobe(ei_strobe),
        .di_strobe(di_strobe),
        .reg_rdata(reg_rdata),
        .flags    (flags),
        .mask     (mask),
        .port_we  (port_we),
        .cmp_we   (cmp_we),
        .gie      (gie)
    );

    irq_out_stage u_out_stage (
        .clk     (clk),
        .rst_n   (rst_n),
        .flags   (flags),
        .mask    (mask),
        .gie     (gie),
        .port_set(set_vec[SRC_PORT]),
        .cmp_set (set_vec[SRC_CMP]),
        .port_we (port_we),
        .cmp_we  (cmp_we),
        .sleep   (sleep),
        .irq     (irq),
        .wake    (wake)
    );

endmodule

// File: rtl/irq_wake_ctrl_chk.sv
// Module irq_wake_ctrl_chk
// Cycle-by-cycle properties of the controller, bound into the top module.
module irq_wake_ctrl_chk
    import irq_wake_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic [1:0]         reg_addr,
    input logic               reg_wr,
    input logic               wdata_tmr,
    input logic [7:0]         reg_rdata,
    input logic               tmr_ovf,
    input logic               di_strobe,
    input logic               sleep,
    input logic               irq,
    input logic               wake,
    input logic [NUM_SRC-1:0] flags,
    input logic [NUM_SRC-1:0] mask
);

    AST_WCTL_SPARE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == ADDR_WCTL) |-> (reg_rdata[6:5] == 2'b00 && !reg_rdata[3] && !reg_rdata[1])); // R2

    AST_STAT_SPARE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == ADDR_STAT) |-> (reg_rdata[7:3] == 5'd0)); // R2

    AST_TMR_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[SRC_TMR]) |-> $past(tmr_ovf)); // R5

    AST_TMR_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flags[SRC_TMR]) |-> $past(reg_wr && reg_addr == ADDR_STAT && !wdata_tmr)); // R6

    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_ovf |=> flags[SRC_TMR]); // R7

    AST_IRQ_NEEDS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (|(flags & mask))); // R8

    AST_DI_SILENCES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        di_strobe |=> !irq); // R9

    AST_WAKE_ONLY_ASLEEP: assert property (@(posedge clk) disable iff (!rst_n)
        wake |-> $past(sleep)); // R10

endmodule

bind irq_wake_ctrl irq_wake_ctrl_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_addr (reg_addr),
    .reg_wr   (reg_wr),
    .wdata_tmr(reg_wdata[0]),
    .reg_rdata(reg_rdata),
    .tmr_ovf  (tmr_ovf),
    .di_strobe(di_strobe),
    .sleep    (sleep),
    .irq      (irq),
    .wake     (wake),
    .flags    (flags),
    .mask     (mask)
);

// File: tb/irq_wake_ctrl_bench.sv
`timescale 1ns/1ps
// Bench for irq_wake_ctrl: driver tasks push expected items into a queue,
// a monitor process pops each one and compares it with the live outputs.
module irq_wake_ctrl_bench;

    localparam int PORT_W = 8;

    typedef struct {
        int         sel;   // 0 = reg_rdata, 1 = irq, 2 = wake
        logic [7:0] exp;
        string      req;
    } item_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ext0_pin = 1'b1;
    logic              ext1_pin = 1'b1;
    logic              cmp_out = 1'b0;
    logic [PORT_W-1:0] port_in = '0;
    logic              tmr_ovf = 1'b0;
    logic [1:0]        reg_addr = 2'd0;
    logic              reg_wr = 1'b0;
    logic [7:0]        reg_wdata = 8'd0;
    logic [7:0]        reg_rdata;
    logic              ei_strobe = 1'b0;
    logic              di_strobe = 1'b0;
    logic              sleep = 1'b0;
    logic              irq;
    logic              wake;

    item_t q[$];
    int    total = 0;
    int    bad = 0;
    bit    done = 1'b0;

    always #4 clk = ~clk;

    irq_wake_ctrl #(.PORT_W(PORT_W)) u_irq_wake_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .ext0_pin (ext0_pin),
        .ext1_pin (ext1_pin),
        .cmp_out  (cmp_out),
        .port_in  (port_in),
        .tmr_ovf  (tmr_ovf),
        .reg_addr (reg_addr),
        .reg_wr   (reg_wr),
        .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .ei_strobe(ei_strobe),
        .di_strobe(di_strobe),
        .sleep    (sleep),
        .irq      (irq),
        .wake     (wake)
    );

    // Monitor: pop each expected item and compare with the live output
    initial begin
        forever begin
            wait (q.size() != 0);
            #1;
            begin
                item_t it;
                logic [7:0] act;
                it = q.pop_front();
                case (it.sel)
                    0:       act = reg_rdata;
                    1:       act = {7'd0, irq};
                    default: act = {7'd0, wake};
                endcase
                total++;
                if (act !== it.exp) begin
                    bad++;
                    $display("FAIL %s: actual=%h expected=%h", it.req, act, it.exp);
                end
            end
        end
    end

    task automatic push(input int sel, input logic [7:0] exp, input string req);
        item_t it;
        it.sel = sel;
        it.exp = exp;
        it.req = req;
        q.push_back(it);
        #2;
    endtask

    task automatic chk_reg(input logic [1:0] a, input logic [7:0] exp, input string req);
        reg_addr = a;
        push(0, exp, req);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    // Wait out the synchronizer: flag visible after the third rising edge
    task automatic settle();
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic tmr_pulse();
        @(negedge clk);
        tmr_ovf = 1'b1;
        @(negedge clk);
        tmr_ovf = 1'b0;
    endtask

    task automatic strobe(input logic e, input logic d);
        @(negedge clk);
        ei_strobe = e;
        di_strobe = d;
        @(negedge clk);
        ei_strobe = 1'b0;
        di_strobe = 1'b0;
    endtask

    // Watchdog
    initial begin
        #1_000_000;
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // Driver
    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        @(negedge clk); chk_reg(2'd0, 8'h00, "R1 wctl");
        @(negedge clk); chk_reg(2'd1, 8'h00, "R1 stat");
        @(negedge clk); chk_reg(2'd2, 8'h00, "R1 mask");
        @(negedge clk); push(1, 8'h00, "R1 irq"); push(2, 8'h00, "R1 wake");

        // R2 layout and spare bits; R6 writes of 1 never set flags
        wr(2'd0, 8'hFF); chk_reg(2'd0, 8'h14, "R2 wctl enables only");
        wr(2'd2, 8'hFF); chk_reg(2'd2, 8'h1F, "R2 mask width");
        wr(2'd1, 8'hFF); chk_reg(2'd1, 8'h00, "R6 stat write ones");
        wr(2'd0, 8'h00); chk_reg(2'd0, 8'h00, "R2 wctl cleared");
        wr(2'd2, 8'h00);

        // R3 external pins
        @(negedge clk); ext0_pin = 1'b0; settle();
        chk_reg(2'd1, 8'h04, "R3 ext0 fall");
        wr(2'd1, 8'h00); chk_reg(2'd1, 8'h00, "R6 ext0 cleared");
        @(negedge clk); ext0_pin = 1'b1; settle(); @(negedge clk);
        chk_reg(2'd1, 8'h00, "R3 ext0 rise ignored");
        @(negedge clk); ext1_pin = 1'b0; settle();
        chk_reg(2'd0, 8'h80, "R3 ext1 fall");

        // R4 comparator both directions
        @(negedge clk); cmp_out = 1'b1; settle();
        chk_reg(2'd0, 8'h81, "R4 cmp rise");
        wr(2'd0, 8'h00); chk_reg(2'd0, 8'h00, "R6 wctl flags cleared");
        @(negedge clk); cmp_out = 1'b0; settle();
        chk_reg(2'd0, 8'h01, "R4 cmp fall");
        wr(2'd0, 8'h00);

        // R5 port change and timer
        @(negedge clk); port_in[2] = 1'b1; settle();
        chk_reg(2'd1, 8'h02, "R5 port change");
        wr(2'd1, 8'h00);
        tmr_pulse(); chk_reg(2'd1, 8'h01, "R5 timer");

        // R6 write 1 keeps, write 0 clears
        wr(2'd1, 8'h01); chk_reg(2'd1, 8'h01, "R6 keep on one");
        wr(2'd1, 8'h06); chk_reg(2'd1, 8'h00, "R6 clear on zero");

        // R7 set wins over same-cycle clear
        @(negedge clk);
        reg_addr = 2'd1; reg_wdata = 8'h00; reg_wr = 1'b1; tmr_ovf = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; tmr_ovf = 1'b0;
        chk_reg(2'd1, 8'h01, "R7 set beats clear");

        // R8 / R9 request gating
        wr(2'd2, 8'h01); push(1, 8'h00, "R8 irq without gie");
        strobe(1'b1, 1'b0); push(1, 8'h01, "R9 ei enables");
        wr(2'd2, 8'h00); push(1, 8'h00, "R8 masked off");
        wr(2'd2, 8'h01); push(1, 8'h01, "R8 mask on");
        strobe(1'b1, 1'b1); push(1, 8'h00, "R9 di wins");
        strobe(1'b1, 1'b0); push(1, 8'h01, "R9 ei again");
        wr(2'd1, 8'h00); push(1, 8'h00, "R8 flag cleared");
        strobe(1'b0, 1'b1);

        // R10 wake pulses
        wr(2'd0, 8'h10);
        @(negedge clk); port_in[5] = 1'b1; settle();
        push(2, 8'h00, "R10 awake no wake");
        sleep = 1'b1;
        @(negedge clk); port_in[5] = 1'b0; settle();
        push(2, 8'h01, "R10 port wake");
        @(negedge clk); push(2, 8'h00, "R10 one cycle");
        wr(2'd0, 8'h00);
        @(negedge clk); cmp_out = 1'b1; settle();
        push(2, 8'h00, "R10 cmp not enabled");
        wr(2'd0, 8'h04);
        @(negedge clk); cmp_out = 1'b0; settle();
        push(2, 8'h01, "R10 cmp wake");
        @(negedge clk); push(2, 8'h00, "R10 cmp one cycle");
        sleep = 1'b0;

        repeat (3) @(negedge clk);
        wait (q.size() == 0);
        #2;
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule